// File: doc/BRIEF.md
# Binary32 NaN Result Selector

This unit sits behind a two-input single-precision floating-point operator. Once the operator has found that at least one of its operands is a NaN, this unit decides which NaN bit pattern becomes the result and whether the invalid-operation exception is raised. It sorts each operand into signaling NaN, quiet NaN, or not a NaN. It then applies one of three priority policies chosen at run time, makes the chosen operand quiet, and registers both the result word and the invalid flag.

A polarity input selects how the most significant fraction bit (bit 22) is read. With polarity 0 that bit set means quiet. With polarity 1 that bit set means signaling. A default-result mode input replaces every propagated NaN with the fixed default NaN for the active polarity. The invalid flag still follows the operands when that mode is on. Deciding whether the NaN path is needed at all, and producing any arithmetic result, are left to the surrounding datapath.

Top module: `nanp_select`

## Requirements
- R1: The result word and invalid flag are registered. Inputs applied before a rising clock edge appear on the outputs after that edge and not before it. While the active-low reset is held, both outputs read zero.
- R2: An operand is a NaN when its exponent field (bits 30:23) is all ones and its fraction (bits 22:0) is nonzero. With polarity 0, a NaN whose bit 22 is 1 is quiet and one whose bit 22 is 0 is signaling. With polarity 1 the meaning of bit 22 is reversed.
- R3: The invalid flag is 1 exactly when at least one operand is a signaling NaN. This holds whether or not default-result mode is on.
- R4: When default-result mode is 1, the result is 32'h7FC00000 under polarity 0 and 32'h7FBFFFFF under polarity 1, whatever the operands are.
- R5: Policy code 0 chooses the first of these that applies: a if a is signaling, b if b is signaling, a if a is quiet, and b otherwise.
- R6: Policy code 1 chooses a whenever a is any kind of NaN, and b otherwise.
- R7: Under policy code 2, a signaling NaN paired with a quiet NaN gives the quiet one, and a NaN paired with an operand that is not a NaN gives the NaN. If neither operand is a NaN, the choice is b.
- R8: Under policy code 2, when both operands are signaling or both are quiet, the choice is the operand whose bits 30:0 (its word shifted left by one) are larger as an unsigned number.
- R9: Under policy code 2, when both operands are of the same class and their bits 30:0 are equal, a is chosen only if a's full 32-bit word is smaller than b's. In effect, a positive a beats a negative b, and in every other tie b is chosen.
- R10: The chosen operand is made quiet before it is output. Under polarity 0, a signaling NaN gets bit 22 set. Under polarity 1, a signaling NaN is replaced by 32'h7FBFFFFF. A quiet NaN, or an operand that is not a NaN, passes through unchanged.
- R11: Policy code 3 behaves exactly like policy code 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op_a | input | 32 | First operand word |
| op_b | input | 32 | Second operand word |
| policy_sel | input | 2 | Priority policy: 0 ordered, 1 first-NaN, 2 magnitude, 3 same as 0 |
| snan_hi | input | 1 | Polarity: 1 means bit 22 set marks a signaling NaN |
| dflt_mode | input | 1 | Force the default NaN onto the result |
| nan_out | output | 32 | Registered NaN result |
| invalid_out | output | 1 | Registered invalid-operation flag |

## Verification
The hardest case to reach is the exact tie under policy 2. It needs two NaNs of the same class with identical bits 30:0 that differ only in sign, and random words almost never produce that. The stimulus therefore builds pairs deliberately: it copies a's low 31 bits into b and sets the two sign bits independently. Every pair is also replayed under both polarities, which swaps the signaling and quiet classes of the same words. Random draws are weighted heavily toward words with an all-ones exponent, so that every policy branch is taken many times.

// File: rtl/nanp_pkg.sv
package nanp_pkg;

  typedef enum logic [1:0] {
    POL_ORDERED   = 2'd0,
    POL_FIRST     = 2'd1,
    POL_MAGNITUDE = 2'd2,
    POL_SPARE     = 2'd3
  } nan_policy_e;

  typedef struct packed {
    logic any;
    logic quiet;
    logic sig;
  } nan_cls_t;

endpackage

// File: rtl/nanp_classify.sv
module nanp_classify
  import nanp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] word,
  input  logic                  snan_hi,
  output nan_cls_t              cls
);
  localparam int W = 1 + EXP_W + FRAC_W;

  function automatic nan_cls_t sort_word(input logic [W-1:0] w, input logic pol);
    nan_cls_t r;
    logic exp_ones, frac_nz, qbit_says_quiet;
    exp_ones        = &w[W-2:FRAC_W];
    frac_nz         = |w[FRAC_W-1:0];
    qbit_says_quiet = w[FRAC_W-1] ^ pol;
    r.any   = exp_ones & frac_nz;
    r.quiet = r.any & qbit_says_quiet;
    r.sig   = r.any & ~qbit_says_quiet;
    return r;
  endfunction

  assign cls = sort_word(word, snan_hi);

endmodule

// File: rtl/nanp_chooser.sv
module nanp_chooser
  import nanp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [EXP_W+FRAC_W:0] a,
  input  logic [EXP_W+FRAC_W:0] b,
  input  nan_cls_t              cls_a,
  input  nan_cls_t              cls_b,
  input  nan_policy_e           policy,
  output logic                  pick_b
);
  localparam int W = 1 + EXP_W + FRAC_W;

  logic [W-2:0] mag_a, mag_b;
  logic         mag_gt, mag_eq, a_larger;

  assign mag_a    = a[W-2:0];
  assign mag_b    = b[W-2:0];
  assign mag_gt   = mag_a > mag_b;
  assign mag_eq   = mag_a == mag_b;
  // equal magnitude: a's raw word is smaller only when a positive, b negative
  assign a_larger = mag_gt | (mag_eq & ~a[W-1] & b[W-1]);

  function automatic logic ordered_pick(input nan_cls_t ca, input nan_cls_t cb);
    if (ca.sig)        return 1'b0;
    else if (cb.sig)   return 1'b1;
    else if (ca.quiet) return 1'b0;
    else               return 1'b1;
  endfunction

  function automatic logic magnitude_pick(input nan_cls_t ca, input nan_cls_t cb,
                                          input logic a_big);
    if (ca.sig) begin
      if (cb.sig) return ~a_big;
      return cb.quiet;
    end else if (ca.quiet) begin
      if (cb.sig || !cb.quiet) return 1'b0;
      return ~a_big;
    end
    return 1'b1;
  endfunction

  always_comb begin
    case (policy)
      POL_FIRST:     pick_b = ~cls_a.any;
      POL_MAGNITUDE: pick_b = magnitude_pick(cls_a, cls_b, a_larger);
      POL_ORDERED,
      POL_SPARE:     pick_b = ordered_pick(cls_a, cls_b);
      default:       pick_b = ordered_pick(cls_a, cls_b);
    endcase
  end

  assert_ordered_bsig_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (policy == POL_ORDERED && cls_b.sig && !cls_a.sig) |-> pick_b);

  assert_first_anyA_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (policy == POL_FIRST && cls_a.any) |-> !pick_b);

  assert_mag_sq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (policy == POL_MAGNITUDE && cls_a.sig && cls_b.quiet) |-> pick_b);

  assert_mag_bigger_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (policy == POL_MAGNITUDE && cls_a.quiet && cls_b.quiet && mag_a < mag_b) |-> pick_b);

  assert_mag_tie_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (policy == POL_MAGNITUDE && cls_a.sig && cls_b.sig && a == b) |-> pick_b);

  assert_spare_aquiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (policy == POL_SPARE && cls_a.quiet && !cls_b.sig) |-> !pick_b);

endmodule

// File: rtl/nanp_quieter.sv
module nanp_quieter #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] word,
  input  logic                  is_sig,
  input  logic                  snan_hi,
  output logic [EXP_W+FRAC_W:0] quiet_word,
  output logic [EXP_W+FRAC_W:0] dflt_word
);
  localparam int W = 1 + EXP_W + FRAC_W;
  localparam logic [FRAC_W-1:0] QBIT = {1'b1, {(FRAC_W-1){1'b0}}};

  function automatic logic [W-1:0] default_nan(input logic pol);
    logic [FRAC_W-1:0] frac;
    frac = pol ? ~QBIT : QBIT;
    return {1'b0, {EXP_W{1'b1}}, frac};
  endfunction

  function automatic logic [W-1:0] silence(input logic [W-1:0] w, input logic s,
                                           input logic pol);
    if (!s)  return w;
    if (pol) return default_nan(pol);
    return w | {{(EXP_W+1){1'b0}}, QBIT};
  endfunction

  assign dflt_word  = default_nan(snan_hi);
  assign quiet_word = silence(word, is_sig, snan_hi);

endmodule

// File: rtl/nanp_select.sv
module nanp_select
  import nanp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [EXP_W+FRAC_W:0] op_a,
  input  logic [EXP_W+FRAC_W:0] op_b,
  input  logic [1:0]            policy_sel,
  input  logic                  snan_hi,
  input  logic                  dflt_mode,
  output logic [EXP_W+FRAC_W:0] nan_out,
  output logic                  invalid_out
);
  localparam int W    = 1 + EXP_W + FRAC_W;
  localparam int NOPS = 2;

  logic [W-1:0] ops [NOPS];
  nan_cls_t     cls [NOPS];
  logic         pick_b;
  logic [W-1:0] chosen, quieted, dflt_word, next_out;
  logic         chosen_sig, raise_inv, nan_in;

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar g = 0; g < NOPS; g++) begin : g_cls
    nanp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .word    (ops[g]),
      .snan_hi (snan_hi),
      .cls     (cls[g])
    );
  end

  nanp_chooser #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_choose (
    .clk    (clk),
    .rst_n  (rst_n),
    .a      (op_a),
    .b      (op_b),
    .cls_a  (cls[0]),
    .cls_b  (cls[1]),
    .policy (nan_policy_e'(policy_sel)),
    .pick_b (pick_b)
  );

  assign chosen     = pick_b ? op_b : op_a;
  assign chosen_sig = pick_b ? cls[1].sig : cls[0].sig;
  assign raise_inv  = cls[0].sig | cls[1].sig;
  assign nan_in     = cls[0].any | cls[1].any;

  nanp_quieter #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_quiet (
    .word       (chosen),
    .is_sig     (chosen_sig),
    .snan_hi    (snan_hi),
    .quiet_word (quieted),
    .dflt_word  (dflt_word)
  );

  assign next_out = dflt_mode ? dflt_word : quieted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nan_out     <= '0;
      invalid_out <= 1'b0;
    end else begin
      nan_out     <= next_out;
      invalid_out <= raise_inv;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (nan_out == '0 && !invalid_out));

  assert_inv_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cls[0].sig || cls[1].sig) |=> invalid_out);

  assert_inv_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cls[0].sig && !cls[1].sig) |=> !invalid_out);

  assert_dflt_pol0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dflt_mode && !snan_hi) |=> (nan_out == {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}}));

  assert_quiet_pol0_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!dflt_mode && !snan_hi && nan_in) |=> nan_out[FRAC_W-1]);

  assert_quiet_pol1_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!dflt_mode && snan_hi && nan_in) |=> !nan_out[FRAC_W-1]);

endmodule

// File: tb/nanp_select_bench.sv
`timescale 1ns/1ps
module nanp_select_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [1:0]  policy_sel = '0;
  logic        snan_hi = 1'b0, dflt_mode = 1'b0;
  logic [31:0] nan_out;
  logic        invalid_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] prev_res = '0;
  logic        prev_inv = 1'b0;

  always #2 clk = ~clk;

  nanp_select u_nanp_select (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
    .policy_sel(policy_sel), .snan_hi(snan_hi), .dflt_mode(dflt_mode),
    .nan_out(nan_out), .invalid_out(invalid_out)
  );

  function automatic bit is_nan(input logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 23'd0);
  endfunction

  function automatic bit is_q(input logic [31:0] x, input bit sp);
    if (!is_nan(x)) return 0;
    return sp ? (x[22] == 1'b0) : (x[22] == 1'b1);
  endfunction

  function automatic bit is_s(input logic [31:0] x, input bit sp);
    return is_nan(x) && !is_q(x, sp);
  endfunction

  // returns 1 when b is the chosen operand
  function automatic bit ref_choose(input logic [31:0] a, b, input int pol, input bit sp);
    bit as, aq, bs, bq, a_big;
    as = is_s(a, sp); aq = is_q(a, sp); bs = is_s(b, sp); bq = is_q(b, sp);
    if (pol == 1) return !(as || aq);
    if (pol == 2) begin
      if ({1'b0, a[30:0]} > {1'b0, b[30:0]})      a_big = 1;
      else if ({1'b0, a[30:0]} < {1'b0, b[30:0]}) a_big = 0;
      else                                        a_big = (a < b);
      if ((as && bs) || (aq && bq)) return !a_big;
      if (as && bq) return 1;
      if (aq && bs) return 0;
      if (as || aq) return 0;
      return 1;
    end
    if (as) return 0;
    if (bs) return 1;
    if (aq) return 0;
    return 1;
  endfunction

  task automatic ref_model(input logic [31:0] a, b, input int pol, input bit sp, dm,
                           output logic [31:0] res, output logic inv);
    logic [31:0] dn, pick;
    dn  = sp ? 32'h7FBFFFFF : 32'h7FC00000;
    inv = is_s(a, sp) || is_s(b, sp);
    pick = ref_choose(a, b, pol, sp) ? b : a;
    if (is_s(pick, sp)) pick = sp ? dn : (pick | 32'h0040_0000);
    res = dm ? dn : pick;
  endtask

  task automatic step(input logic [31:0] a, b, input int pol, input bit sp, dm,
                      input string tag);
    logic [31:0] er;
    logic        ei;
    ref_model(a, b, pol, sp, dm, er, ei);
    op_a = a; op_b = b; policy_sel = pol[1:0]; snan_hi = sp; dflt_mode = dm;
    #1;
    checks++;
    if (nan_out !== prev_res) begin
      errors++;
      $display("FAIL R1 early change act %h exp %h", nan_out, prev_res);
    end
    @(negedge clk);
    checks++;
    if (nan_out !== er) begin
      errors++;
      $display("FAIL %s nan_out act %h exp %h (a=%h b=%h pol=%0d sp=%0d dm=%0d)",
               tag, nan_out, er, a, b, pol, sp, dm);
    end
    checks++;
    if (invalid_out !== ei) begin
      errors++;
      $display("FAIL R3 invalid act %b exp %b (a=%h b=%h sp=%0d)", invalid_out, ei, a, b, sp);
    end
    prev_res = er;
    prev_inv = ei;
  endtask

  function automatic string tag_of(input logic [31:0] a, b, input int pol, input bit sp, dm);
    if (dm) return "R4";
    if (pol == 3) return "R11";
    if (pol == 1) return "R6";
    if (pol == 0) return "R5";
    if ((is_s(a, sp) && is_s(b, sp)) || (is_q(a, sp) && is_q(b, sp)))
      return (a[30:0] == b[30:0]) ? "R9" : "R8";
    return "R7";
  endfunction

  function automatic logic [31:0] rand_word();
    int k;
    k = $urandom_range(0, 9);
    case (k)
      0: return {$urandom_range(0, 1) == 1, 8'hFF, 23'd0};
      1: return $urandom & 32'h7F7FFFFF;
      2: return {$urandom_range(0, 1) == 1, 8'hFF, 1'b0, 22'd1 + 22'($urandom_range(0, 3))};
      3: return {$urandom_range(0, 1) == 1, 8'hFF, 1'b1, 22'($urandom_range(0, 3))};
      default: return {$urandom_range(0, 1) == 1, 8'hFF, 1'($urandom), 22'($urandom) | 22'd1};
    endcase
  endfunction

  localparam logic [31:0] Q0A = 32'h7FC00011;  // quiet under polarity 0
  localparam logic [31:0] Q0B = 32'hFFC00022;
  localparam logic [31:0] S0A = 32'h7F800033;  // signaling under polarity 0
  localparam logic [31:0] S0B = 32'hFF800044;
  localparam logic [31:0] NUM = 32'h3F800000;

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (nan_out !== 32'd0 || invalid_out !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset act %h/%b exp 00000000/0", nan_out, invalid_out);
    end
    rst_n = 1'b1;
    @(negedge clk);

    step(S0A, NUM, 0, 0, 0, "R10");
    step(Q0A, S0B, 0, 0, 0, "R5");
    step(Q0A, Q0B, 0, 0, 0, "R5");
    step(NUM, Q0B, 0, 0, 0, "R5");
    step(Q0A, S0B, 3, 0, 0, "R11");
    step(NUM, S0B, 3, 0, 0, "R11");
    step(Q0A, S0B, 1, 0, 0, "R6");
    step(NUM, S0B, 1, 0, 0, "R6");
    step(S0A, Q0B, 2, 0, 0, "R7");
    step(Q0A, S0B, 2, 0, 0, "R7");
    step(NUM, S0B, 2, 0, 0, "R7");
    step(32'h7FC00005, 32'h7FC00009, 2, 0, 0, "R8");
    step(32'hFFC00009, 32'h7FC00005, 2, 0, 0, "R8");
    step(32'h7F800007, 32'hFF800007, 2, 0, 0, "R9");
    step(32'hFF800007, 32'h7F800007, 2, 0, 0, "R9");
    step(32'h7FC00007, 32'h7FC00007, 2, 0, 0, "R9");
    step(S0A, Q0B, 0, 0, 1, "R4");
    step(Q0A, NUM, 1, 1, 1, "R4");
    step(Q0A, NUM, 0, 1, 0, "R10");
    step(S0A, NUM, 0, 1, 0, "R2");
    step(Q0A, S0A, 0, 1, 0, "R2");
    step(32'hFFBFFFF0, NUM, 1, 1, 0, "R10");

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, b;
      int pol;
      bit sp, dm;
      a = rand_word();
      b = rand_word();
      if ($urandom_range(0, 3) == 0) b = {1'($urandom), a[30:0]};
      pol = $urandom_range(0, 3);
      sp  = 1'($urandom);
      dm  = ($urandom_range(0, 7) == 0);
      step(a, b, pol, sp, dm, tag_of(a, b, pol, sp, dm));
      step(a, b, pol, !sp, dm, tag_of(a, b, pol, !sp, dm));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule